// File: doc/BRIEF.md
# Row-Parallel Block Transfer Engine

This engine moves rectangular regions of image data between a banked on-chip row memory and a 64-bit, word-serial external memory port. The row memory is organised as `LANES` byte lanes. Each row address selects one byte in every lane, and consecutive groups of eight lanes form 64-bit lane groups. Each transfer request names a direction, a first row, an inclusive range of lane groups, a row count and an external word address. The engine then works through the rectangle one row at a time.

For every row, the whole row crosses between the lane memories and a chain of 64-bit shift-register line buffers in a single memory cycle. The engine borrows that cycle from the array by raising `lm_req` and waiting for `lm_grant`. The selected groups are then streamed one 64-bit beat per cycle over valid/ready handshakes on the external side, so the array keeps nearly all of its memory bandwidth.

Requests enter through a valid/ready push port into one of two in-order queues, one high priority and one low priority. `req_ready` drops when the queue that the current push targets is full. Holding `req_valid` with a stable descriptor is then the caller's back-pressure rule. On the outbound stream, `ext_wvalid` stays high with stable data and address until `ext_wready` is seen. On the inbound stream, a word is taken only in a cycle where `ext_rready` and `ext_rvalid` are both high.

Top module: `row_dma_engine`

## Requirements
- R1: Each queue holds `QDEPTH` (32) descriptors. `req_ready` is low exactly when the queue selected by `req_hi` holds `QDEPTH` entries, and a push takes place only when `req_valid` and `req_ready` are both high. A full low queue does not block pushes to the high queue.
- R2: Whenever the engine picks its next request, it takes the head of the high queue if that queue is non-empty, and the head of the low queue otherwise.
- R3: Requests from the same queue are carried out in the order they were pushed.
- R4: An outbound request (`req_to_ext`=1) reads rows `req_row` .. `req_row+req_rows_m1`, one per grant. The row count field holds the number of rows minus one.
- R5: Outbound beats carry groups `req_grp_first`..`req_grp_last` in ascending order. Lane L occupies bits [8L+7:8L] of the row bus, and the beat for group g is bits [64g+63:64g], so its lowest lane sits in bits [7:0].
- R6: `ext_addr` starts at `req_ext_addr` and advances by one after each accepted beat. It runs on unbroken across row boundaries.
- R7: An inbound request (`req_to_ext`=0) collects one beat per selected group and then performs one write cycle with `lm_we`=1. In that cycle, `lm_grp_en` bit g is set exactly for the groups in range, and group g carries beat g-`req_grp_first`. Groups outside the range stay unchanged in memory.
- R8: While waiting for a grant, `lm_req` stays high and `lm_row`/`lm_we` stay stable. No external beat is offered or accepted during that wait.
- R9: While `ext_wvalid` is high and `ext_wready` is low, `ext_wvalid`, `ext_wdata` and `ext_addr` hold their values into the next cycle.
- R10: `done` is a single-cycle pulse, raised once per completed request after its last row has finished.
- R11: After reset, `req_ready` is high and `lm_req`, `ext_wvalid`, `ext_rready` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Descriptor push valid |
| req_ready | output | 1 | Selected queue has room |
| req_hi | input | 1 | 1 selects the high-priority queue |
| req_to_ext | input | 1 | 1: row memory to external, 0: external to row memory |
| req_row | input | ROW_W | First row address |
| req_grp_first | input | GI_W | Lowest lane group in the rectangle |
| req_grp_last | input | GI_W | Highest lane group in the rectangle |
| req_rows_m1 | input | CNT_W | Row count minus one |
| req_ext_addr | input | ADDR_W | External word address of the first beat |
| lm_req | output | 1 | Request for one lane-memory cycle |
| lm_grant | input | 1 | Array grants the slot in this cycle |
| lm_we | output | 1 | Slot is a write |
| lm_row | output | ROW_W | Row address of the slot |
| lm_grp_en | output | NGRP | Per-group write enables |
| lm_wdata | output | LANES*8 | Row write data |
| lm_rdata | input | LANES*8 | Row read data, valid in the granted cycle |
| ext_addr | output | ADDR_W | Word address of the current beat |
| ext_wvalid | output | 1 | Outbound beat valid |
| ext_wready | input | 1 | External side accepts the outbound beat |
| ext_wdata | output | 64 | Outbound beat data |
| ext_rvalid | input | 1 | Inbound beat valid |
| ext_rready | output | 1 | Engine accepts an inbound beat |
| ext_rdata | input | 64 | Inbound beat data for `ext_addr` |
| done | output | 1 | Request completion pulse |

## Verification
The assertions assume that every descriptor has `req_grp_first` no greater than `req_grp_last`. They also assume that `lm_rdata` reflects `lm_row` in the cycle `lm_grant` is high, and that `ext_rdata` is the word at the current `ext_addr` whenever `ext_rvalid` is high. The stimulus builds every descriptor with an ordered group range. Its memory models answer combinationally from the addresses the engine presents. Grant and ready are driven only between clock edges, in stall and alternating patterns, so the hold rules on both sides are exercised under real waits.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MEM  = 2'd1,
    ST_BEAT = 2'd2
  } rdma_state_t;
endpackage

// File: rtl/rdma_queue.sv
module rdma_queue #(
  parameter int W     = 8,
  parameter int DEPTH = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  output logic         full,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] slots [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          do_push, do_pop;

  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign full    = cnt == (AW+1)'(DEPTH);
  assign empty   = cnt == '0;
  assign rdata   = slots[rp];

  always_ff @(posedge clk) begin
    if (do_push) slots[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + AW'(1);
      if (do_pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + AW'(1);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + (AW+1)'(1);
        2'b01:   cnt <= cnt - (AW+1)'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  // R1
  q_occupancy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (AW+1)'(DEPTH));

  // R3
  q_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/rdma_linebuf.sv
module rdma_linebuf #(
  parameter int NGRP  = 16,
  parameter int GRP_W = 64
) (
  input  logic                      clk,
  input  logic [$clog2(NGRP)-1:0]   first,
  input  logic [$clog2(NGRP)-1:0]   last,
  input  logic                      load,
  input  logic                      shift,
  input  logic [NGRP*GRP_W-1:0]     row_in,
  input  logic [GRP_W-1:0]          beat_in,
  output logic [GRP_W-1:0]          beat_out,
  output logic [NGRP*GRP_W-1:0]     row_out
);
  localparam int GI_W = $clog2(NGRP);

  logic [GRP_W-1:0] lb     [NGRP];
  logic [GRP_W-1:0] grp_in [NGRP];

  for (genvar g = 0; g < NGRP; g++) begin : g_split
    assign grp_in[g] = row_in[g*GRP_W +: GRP_W];
  end

  // Load aligns group 'first' to the head of the chain; shifting moves
  // every stage one step toward the head and feeds the tail.
  always_ff @(posedge clk) begin
    if (load) begin
      for (int k = 0; k < NGRP; k++) begin
        if (int'(first) + k < NGRP) lb[k] <= grp_in[GI_W'(int'(first) + k)];
        else                        lb[k] <= '0;
      end
    end else if (shift) begin
      for (int k = 0; k < NGRP-1; k++) lb[k] <= lb[k+1];
      lb[NGRP-1] <= beat_in;
    end
  end

  assign beat_out = lb[0];

  // After n inbound shifts beat j sits at stage NGRP-n+j.
  always_comb begin
    row_out = '0;
    for (int g = 0; g < NGRP; g++) begin
      if (g >= int'(first) && g <= int'(last))
        row_out[g*GRP_W +: GRP_W] = lb[GI_W'(g + NGRP - 1 - int'(last))];
    end
  end
endmodule

// File: rtl/rdma_seq.sv
module rdma_seq
  import rdma_pkg::*;
#(
  parameter int NGRP   = 16,
  parameter int ROW_W  = 11,
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 24
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     avail,
  output logic                     take,
  input  logic                     d_to_ext,
  input  logic [ROW_W-1:0]         d_row,
  input  logic [$clog2(NGRP)-1:0]  d_first,
  input  logic [$clog2(NGRP)-1:0]  d_last,
  input  logic [CNT_W-1:0]         d_rows_m1,
  input  logic [ADDR_W-1:0]        d_addr,
  output logic                     lm_req,
  input  logic                     lm_grant,
  output logic                     lm_we,
  output logic [ROW_W-1:0]         lm_row,
  output logic [NGRP-1:0]          lm_grp_en,
  output logic                     lb_load,
  output logic                     lb_shift,
  output logic [$clog2(NGRP)-1:0]  g_first,
  output logic [$clog2(NGRP)-1:0]  g_last,
  output logic [ADDR_W-1:0]        ext_addr,
  output logic                     ext_wvalid,
  input  logic                     ext_wready,
  input  logic                     ext_rvalid,
  output logic                     ext_rready,
  output logic                     done
);
  localparam int GI_W = $clog2(NGRP);
  localparam int BC_W = GI_W + 1;

  rdma_state_t       st;
  logic              to_ext;
  logic [ROW_W-1:0]  row_cur;
  logic [CNT_W-1:0]  rows_left;
  logic [ADDR_W-1:0] addr;
  logic [BC_W-1:0]   nbeats, beat_left;
  logic              beat_hit, last_beat, last_row;

  assign take       = (st == ST_IDLE) && avail;
  assign lm_req     = st == ST_MEM;
  assign lm_we      = lm_req && !to_ext;
  assign lm_row     = row_cur;
  assign ext_wvalid = (st == ST_BEAT) && to_ext;
  assign ext_rready = (st == ST_BEAT) && !to_ext;
  assign ext_addr   = addr;
  assign beat_hit   = (ext_wvalid && ext_wready) || (ext_rready && ext_rvalid);
  assign last_beat  = beat_left == BC_W'(1);
  assign last_row   = rows_left == '0;
  assign lb_load    = lm_req && lm_grant && to_ext;
  assign lb_shift   = beat_hit;

  for (genvar g = 0; g < NGRP; g++) begin : g_en
    assign lm_grp_en[g] = lm_we && (GI_W'(g) >= g_first) && (GI_W'(g) <= g_last);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      done      <= 1'b0;
      to_ext    <= 1'b0;
      row_cur   <= '0;
      g_first   <= '0;
      g_last    <= '0;
      rows_left <= '0;
      addr      <= '0;
      nbeats    <= '0;
      beat_left <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (avail) begin
          to_ext    <= d_to_ext;
          row_cur   <= d_row;
          g_first   <= d_first;
          g_last    <= d_last;
          rows_left <= d_rows_m1;
          addr      <= d_addr;
          nbeats    <= BC_W'(d_last) - BC_W'(d_first) + BC_W'(1);
          beat_left <= BC_W'(d_last) - BC_W'(d_first) + BC_W'(1);
          st        <= d_to_ext ? ST_MEM : ST_BEAT;
        end
        ST_MEM: if (lm_grant) begin
          if (to_ext) begin
            st <= ST_BEAT;
          end else begin
            row_cur   <= row_cur + ROW_W'(1);
            beat_left <= nbeats;
            if (last_row) begin
              done <= 1'b1;
              st   <= ST_IDLE;
            end else begin
              rows_left <= rows_left - CNT_W'(1);
              st        <= ST_BEAT;
            end
          end
        end
        ST_BEAT: if (beat_hit) begin
          addr      <= addr + ADDR_W'(1);
          beat_left <= beat_left - BC_W'(1);
          if (last_beat) begin
            if (to_ext) begin
              beat_left <= nbeats;
              row_cur   <= row_cur + ROW_W'(1);
              if (last_row) begin
                done <= 1'b1;
                st   <= ST_IDLE;
              end else begin
                rows_left <= rows_left - CNT_W'(1);
                st        <= ST_MEM;
              end
            end else begin
              st <= ST_MEM;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R8
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lm_req && !lm_grant |=> lm_req && $stable(lm_row) && $stable(lm_we));

  // R8
  no_beat_in_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lm_req |-> !ext_wvalid && !ext_rready);

  // R9
  wvalid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_wvalid && !ext_wready |=> ext_wvalid && $stable(ext_addr));

  // R6
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_hit |=> ext_addr == $past(ext_addr) + ADDR_W'(1));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  grp_en_only_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lm_we |-> lm_grp_en == '0);
endmodule

// File: rtl/row_dma_engine.sv
module row_dma_engine #(
  parameter int LANES     = 128,
  parameter int GRP_LANES = 8,
  parameter int ROW_W     = 11,
  parameter int CNT_W     = 8,
  parameter int ADDR_W    = 24,
  parameter int QDEPTH    = 32
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               req_valid,
  output logic                               req_ready,
  input  logic                               req_hi,
  input  logic                               req_to_ext,
  input  logic [ROW_W-1:0]                   req_row,
  input  logic [$clog2(LANES/GRP_LANES)-1:0] req_grp_first,
  input  logic [$clog2(LANES/GRP_LANES)-1:0] req_grp_last,
  input  logic [CNT_W-1:0]                   req_rows_m1,
  input  logic [ADDR_W-1:0]                  req_ext_addr,
  output logic                               lm_req,
  input  logic                               lm_grant,
  output logic                               lm_we,
  output logic [ROW_W-1:0]                   lm_row,
  output logic [LANES/GRP_LANES-1:0]         lm_grp_en,
  output logic [LANES*8-1:0]                 lm_wdata,
  input  logic [LANES*8-1:0]                 lm_rdata,
  output logic [ADDR_W-1:0]                  ext_addr,
  output logic                               ext_wvalid,
  input  logic                               ext_wready,
  output logic [GRP_LANES*8-1:0]             ext_wdata,
  input  logic                               ext_rvalid,
  output logic                               ext_rready,
  input  logic [GRP_LANES*8-1:0]             ext_rdata,
  output logic                               done
);
  localparam int NGRP   = LANES / GRP_LANES;
  localparam int GI_W   = $clog2(NGRP);
  localparam int GRP_W  = GRP_LANES * 8;
  localparam int DESC_W = 1 + ROW_W + 2*GI_W + CNT_W + ADDR_W;

  logic [DESC_W-1:0] req_desc, sel_desc;
  logic [DESC_W-1:0] q_rd [2];
  logic [1:0]        q_push, q_pop, q_full, q_empty;
  logic              take, sel_hi, lb_load, lb_shift;
  logic [GI_W-1:0]   g_first, g_last;

  logic              d_to_ext;
  logic [ROW_W-1:0]  d_row;
  logic [GI_W-1:0]   d_first, d_last;
  logic [CNT_W-1:0]  d_rows_m1;
  logic [ADDR_W-1:0] d_addr;

  assign req_desc  = {req_to_ext, req_row, req_grp_first, req_grp_last, req_rows_m1, req_ext_addr};
  assign req_ready = req_hi ? !q_full[1] : !q_full[0];
  assign q_push[1] = req_valid && req_hi && !q_full[1];
  assign q_push[0] = req_valid && !req_hi && !q_full[0];

  for (genvar q = 0; q < 2; q++) begin : g_queue
    rdma_queue #(.W(DESC_W), .DEPTH(QDEPTH)) u_queue (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (q_push[q]),
      .wdata (req_desc),
      .full  (q_full[q]),
      .pop   (q_pop[q]),
      .rdata (q_rd[q]),
      .empty (q_empty[q])
    );
  end

  // Fixed priority: high queue head wins whenever it exists.
  assign sel_hi   = !q_empty[1];
  assign sel_desc = sel_hi ? q_rd[1] : q_rd[0];
  assign q_pop[1] = take && sel_hi;
  assign q_pop[0] = take && !sel_hi;
  assign {d_to_ext, d_row, d_first, d_last, d_rows_m1, d_addr} = sel_desc;

  rdma_seq #(.NGRP(NGRP), .ROW_W(ROW_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .avail      (!q_empty[0] || !q_empty[1]),
    .take       (take),
    .d_to_ext   (d_to_ext),
    .d_row      (d_row),
    .d_first    (d_first),
    .d_last     (d_last),
    .d_rows_m1  (d_rows_m1),
    .d_addr     (d_addr),
    .lm_req     (lm_req),
    .lm_grant   (lm_grant),
    .lm_we      (lm_we),
    .lm_row     (lm_row),
    .lm_grp_en  (lm_grp_en),
    .lb_load    (lb_load),
    .lb_shift   (lb_shift),
    .g_first    (g_first),
    .g_last     (g_last),
    .ext_addr   (ext_addr),
    .ext_wvalid (ext_wvalid),
    .ext_wready (ext_wready),
    .ext_rvalid (ext_rvalid),
    .ext_rready (ext_rready),
    .done       (done)
  );

  rdma_linebuf #(.NGRP(NGRP), .GRP_W(GRP_W)) u_linebuf (
    .clk      (clk),
    .first    (g_first),
    .last     (g_last),
    .load     (lb_load),
    .shift    (lb_shift),
    .row_in   (lm_rdata),
    .beat_in  (ext_rdata),
    .beat_out (ext_wdata),
    .row_out  (lm_wdata)
  );

  // R2
  lo_after_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_pop[0] |-> q_empty[1]);

  // R9
  wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_wvalid && !ext_wready |=> $stable(ext_wdata));

  // R1
  push_when_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_hi && q_full[1] |=> $stable(q_full[1]) || q_pop[1] || $past(q_pop[1]));
endmodule

// File: tb/row_dma_engine_tb.sv
module row_dma_engine_tb;
  localparam int LANES  = 128;
  localparam int NG     = 16;
  localparam int RB     = LANES * 8;
  localparam int ROW_W  = 11;
  localparam int CNT_W  = 8;
  localparam int ADDR_W = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic              req_valid = 1'b0, req_hi = 1'b0, req_to_ext = 1'b0;
  logic              req_ready;
  logic [ROW_W-1:0]  req_row = '0;
  logic [3:0]        req_grp_first = '0, req_grp_last = '0;
  logic [CNT_W-1:0]  req_rows_m1 = '0;
  logic [ADDR_W-1:0] req_ext_addr = '0;
  logic              lm_req, lm_we;
  logic              lm_grant = 1'b0;
  logic [ROW_W-1:0]  lm_row;
  logic [NG-1:0]     lm_grp_en;
  logic [RB-1:0]     lm_wdata, lm_rdata;
  logic [ADDR_W-1:0] ext_addr;
  logic              ext_wvalid, ext_rready, done;
  logic              ext_wready = 1'b0, ext_rvalid = 1'b0;
  logic [63:0]       ext_wdata;
  logic [63:0]       ext_rdata = '0;

  row_dma_engine u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_hi(req_hi), .req_to_ext(req_to_ext), .req_row(req_row),
    .req_grp_first(req_grp_first), .req_grp_last(req_grp_last),
    .req_rows_m1(req_rows_m1), .req_ext_addr(req_ext_addr),
    .lm_req(lm_req), .lm_grant(lm_grant), .lm_we(lm_we), .lm_row(lm_row),
    .lm_grp_en(lm_grp_en), .lm_wdata(lm_wdata), .lm_rdata(lm_rdata),
    .ext_addr(ext_addr), .ext_wvalid(ext_wvalid), .ext_wready(ext_wready),
    .ext_wdata(ext_wdata), .ext_rvalid(ext_rvalid), .ext_rready(ext_rready),
    .ext_rdata(ext_rdata), .done(done)
  );

  // ---------------- models ----------------
  logic [RB-1:0] bmem [32];
  logic [63:0]   xmem [512];
  int stall = 0, wr_mode = 0, rd_mode = 0, wcnt = 0, cyc = 0;
  bit gnt_block = 1'b0;
  int done_n = 0, gnt_n = 0, log_n = 0, wait_bad = 0;
  logic [ADDR_W-1:0] log_a [128];
  int checks = 0, errs = 0;

  function automatic logic [7:0] lane_init(int r, int l);
    return 8'((r*29 + l*3 + 7) & 255);
  endfunction
  function automatic logic [63:0] grp_word(int r, int g);
    logic [63:0] w;
    for (int j = 0; j < 8; j++) w[8*j +: 8] = lane_init(r, 8*g + j);
    return w;
  endfunction
  function automatic logic [63:0] xw(int a);
    return {16'hBEEF, 16'(a), 16'(a*7 + 3), 16'(~a)};
  endfunction

  assign lm_rdata = bmem[lm_row[4:0]];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < 32; r++)
        for (int l = 0; l < LANES; l++) bmem[r][8*l +: 8] <= lane_init(r, l);
      for (int a = 0; a < 512; a++) xmem[a] <= xw(a);
    end else begin
      if (lm_req && lm_grant) begin
        gnt_n <= gnt_n + 1;
        if (lm_we)
          for (int g = 0; g < NG; g++)
            if (lm_grp_en[g]) bmem[lm_row[4:0]][64*g +: 64] <= lm_wdata[64*g +: 64];
      end
      if (ext_wvalid && ext_wready) begin
        xmem[ext_addr[8:0]] <= ext_wdata;
        log_a[log_n[6:0]] <= ext_addr;
        log_n <= log_n + 1;
      end
      if (done) done_n <= done_n + 1;
      if (lm_req && (ext_wvalid || ext_rready)) wait_bad <= wait_bad + 1;
    end
  end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (!lm_req || gnt_block) begin lm_grant <= 1'b0; wcnt <= 0; end
    else if (wcnt >= stall) lm_grant <= 1'b1;
    else begin wcnt <= wcnt + 1; lm_grant <= 1'b0; end
    ext_wready <= (wr_mode == 0) ? 1'b1 : cyc[0];
    ext_rvalid <= (rd_mode == 0) ? 1'b1 : ~cyc[0];
    ext_rdata  <= xmem[ext_addr[8:0]];
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push_req(input bit hi, input bit te, input int row, input int f, input int l,
                          input int rm1, input int a);
    @(negedge clk);
    req_valid = 1'b1; req_hi = hi; req_to_ext = te;
    req_row = ROW_W'(row); req_grp_first = 4'(f); req_grp_last = 4'(l);
    req_rows_m1 = CNT_W'(rm1); req_ext_addr = ADDR_W'(a);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(input int target, input string req);
    int t = 0;
    while (done_n < target && t < 4000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
    chk(done_n == target, req, 64'(done_n), 64'(target));
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    @(negedge clk);
    chk(req_ready == 1'b1, "R11 req_ready", 64'(req_ready), 64'd1);
    chk(lm_req == 1'b0, "R11 lm_req", 64'(lm_req), 64'd0);
    chk(ext_wvalid == 1'b0, "R11 ext_wvalid", 64'(ext_wvalid), 64'd0);
    chk(ext_rready == 1'b0, "R11 ext_rready", 64'(ext_rready), 64'd0);
    chk(done == 1'b0, "R11 done", 64'(done), 64'd0);
  endtask

  task automatic t_out_full_row();
    int bad = 0; int l0 = log_n;
    stall = 0; wr_mode = 0;
    push_req(1'b0, 1'b1, 3, 0, 15, 0, 'h10);
    wait_done(1, "R10 full row done");
    for (int g = 0; g < NG; g++) if (xmem['h10 + g] !== grp_word(3, g)) bad++;
    chk(bad == 0, "R5 full row beats", 64'(bad), 64'd0);
    chk(log_n - l0 == 16, "R6 full row beat count", 64'(log_n - l0), 64'd16);
  endtask

  task automatic t_out_partial_stall();
    int bad = 0; int g0 = gnt_n;
    stall = 3; wr_mode = 1;
    push_req(1'b1, 1'b1, 8, 5, 7, 2, 'h40);
    wait_done(2, "R10 partial done");
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3; j++) if (xmem['h40 + 3*i + j] !== grp_word(8 + i, 5 + j)) bad++;
    chk(bad == 0, "R4 R5 R6 partial rectangle", 64'(bad), 64'd0);
    chk(gnt_n - g0 == 3, "R4 one slot per row", 64'(gnt_n - g0), 64'd3);
    chk(wait_bad == 0, "R8 no beats while waiting", 64'(wait_bad), 64'd0);
  endtask

  task automatic t_in_partial();
    int bad_in = 0, bad_out = 0;
    stall = 2; rd_mode = 1;
    push_req(1'b0, 1'b0, 20, 2, 9, 1, 'h100);
    wait_done(3, "R10 inbound done");
    for (int i = 0; i < 2; i++)
      for (int g = 0; g < NG; g++) begin
        if (g >= 2 && g <= 9) begin
          if (bmem[20 + i][64*g +: 64] !== xw('h100 + 8*i + g - 2)) bad_in++;
        end else if (bmem[20 + i][64*g +: 64] !== grp_word(20 + i, g)) bad_out++;
      end
    chk(bad_in == 0, "R7 inbound groups written", 64'(bad_in), 64'd0);
    chk(bad_out == 0, "R7 groups outside range kept", 64'(bad_out), 64'd0);
  endtask

  task automatic t_priority();
    int l0 = log_n;
    stall = 6; wr_mode = 0;
    push_req(1'b0, 1'b1, 1, 0, 0, 3, 'h180);
    push_req(1'b0, 1'b1, 2, 1, 1, 0, 'h190);
    push_req(1'b1, 1'b1, 4, 2, 2, 0, 'h1A0);
    wait_done(6, "R10 three requests");
    chk(log_a[7'(l0 + 4)] == ADDR_W'('h1A0), "R2 high queue served first", 64'(log_a[7'(l0 + 4)]), 64'h1A0);
    chk(log_a[7'(l0 + 5)] == ADDR_W'('h190), "R3 low request after", 64'(log_a[7'(l0 + 5)]), 64'h190);
    chk(xmem['h1A0] === grp_word(4, 2), "R5 high request data", xmem['h1A0], grp_word(4, 2));
  endtask

  task automatic t_queue_full();
    int bad = 0; int l0 = log_n;
    stall = 0; gnt_block = 1'b1;
    for (int k = 0; k < 33; k++) push_req(1'b0, 1'b1, 12, 0, 0, 0, 'h1C0 + k);
    @(negedge clk);
    req_hi = 1'b0;
    #1;
    chk(req_ready == 1'b0, "R1 low queue full", 64'(req_ready), 64'd0);
    req_hi = 1'b1;
    #1;
    chk(req_ready == 1'b1, "R1 high queue still open", 64'(req_ready), 64'd1);
    req_hi = 1'b0;
    gnt_block = 1'b0;
    wait_done(39, "R10 drained queue");
    for (int k = 0; k < 33; k++) if (log_a[7'(l0 + k)] != ADDR_W'('h1C0 + k)) bad++;
    chk(bad == 0, "R3 in-order service", 64'(bad), 64'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_out_full_row();
    t_out_partial_stall();
    t_in_partial();
    t_priority();
    t_queue_full();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errs++;
    $display("FAIL watchdog: run did not complete actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule